// File: doc/BRIEF.md
# Serial ROM-to-Scan-Cache Loader

This block fills an internal scan cache with a PLL configuration bitstream that it reads out of a one-bit-wide external ROM. A single-cycle load request makes it walk the ROM address up from zero, one address per clock, with the ROM read enable asserted. Each returned bit goes into the cache slot of the address that produced it. The cache length is fixed per instance by a parameter and is 234, 180 or 144 bits. A later single-cycle reconfigure request streams the cached bits out, lowest index first, on a serial data output paired with a scan clock enable. This is the stream that programs the target PLL's scan chain.

The controller is a single state machine. It has six states:
- `ST_IDLE` waits for a request.
- `ST_ARM` and `ST_HOLD` are the two fixed start-up cycles after a load request.
- `ST_FETCH` issues one ROM address per cycle.
- `ST_DRAIN` waits one cycle so the final ROM bit can be captured.
- `ST_SHIFT` streams the cache out.

It has these transitions:
- IDLE→ARM on a load request.
- IDLE→SHIFT on a reconfigure request when there is no load request.
- ARM→HOLD→FETCH unconditionally.
- FETCH→DRAIN once the last address has been issued.
- DRAIN→IDLE.
- SHIFT→IDLE after the last bit.
- ARM, HOLD or FETCH → IDLE on an address-restart pulse.

The external reset passes through a two-stage synchronizer before the logic uses it. The ROM, the multiplexer in front of it and the PLL lie outside the block.

Top module: `scan_cache_loader`

## Requirements
- R1: While the reset input is high, and after it is released through the two-flop synchronizer, busy, ROM enable, ROM address, scan data and scan clock enable all read 0.
- R2: In idle, a clock edge that samples the load request high sets busy after that same edge (edge t=0).
- R3: At edge t=2, the second edge after the load request returns low, the ROM address becomes 0 and the ROM enable rises.
- R4: While the ROM enable stays high, the address rises by exactly one per clock, so after edge t it is t-2. The ROM bit that arrives in the cycle after an address is presented is stored at that address's cache index.
- R5: The cache length L is set by CHAIN_KIND: 0 gives 234, 1 gives 180, 2 gives 144. The last address issued is L-1. The ROM enable falls at edge L+2 and busy falls at edge L+3. The address then holds at L-1.
- R6: A one-cycle address-restart pulse clears the address and the ROM enable at the next edge. If a load is in progress it is abandoned and busy drops. The next load starts again at address 0.
- R7: A reconfigure request in idle sets busy. After edge t, for t from 0 to L-1, the scan clock enable is high and scan data equals cache bit t. At edge L the scan clock enable, scan data and busy all return to 0.
- R8: A load or reconfigure request made while busy is high has no effect: the running load or shift keeps its timing and data, and no ROM read starts during a shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_in | input | 1 | Asynchronous reset, active high, synchronized internally |
| wr_rom | input | 1 | One-cycle request to load the cache from ROM |
| rom_bit | input | 1 | Serial ROM data, one cycle behind its address |
| rst_addr | input | 1 | One-cycle request to restart the ROM address at 0 |
| reconfig | input | 1 | One-cycle request to stream the cache to the scan chain |
| rom_addr | output | AW | ROM address (AW = clog2(L+1)) |
| rom_en | output | 1 | ROM read enable |
| busy | output | 1 | Load or shift in progress |
| scan_dout | output | 1 | Serial scan data |
| scan_ce | output | 1 | Scan clock enable, high while scan_dout is valid |

## Verification
The assertions assume the following about the inputs:
- Every request is a single-cycle pulse.
- The ROM answers each presented address with its bit in the following cycle.
- An address-restart pulse never shares a cycle with a load request.

The stimulus meets these assumptions by driving every request as a one-clock pulse at the falling edge. A ROM model returns the bit for the address it saw at the previous edge. Restart pulses are issued only in cycles where no other request is driven. Requests made while busy are placed mid-operation, so that they cannot coincide with the start or end of a load or shift.

// File: rtl/slc_pkg.sv
package slc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARM,
        ST_HOLD,
        ST_FETCH,
        ST_DRAIN,
        ST_SHIFT
    } slc_state_e;

    // Cache length chosen per scan-chain flavour.
    function automatic int chain_len(input int kind);
        case (kind)
            1:       return 180;
            2:       return 144;
            default: return 234;
        endcase
    endfunction

endpackage

// File: rtl/slc_reset_sync.sv
module slc_reset_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_in,
    output logic rst_out
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or posedge rst_in) begin
        if (rst_in) chain <= '1;
        else        chain <= {chain[STAGES-2:0], 1'b0};
    end

    assign rst_out = chain[STAGES-1];
endmodule

// File: rtl/slc_addr_ctr.sv
module slc_addr_ctr #(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          inc,
    output logic [AW-1:0] count
);
    always_ff @(posedge clk) begin
        if (rst || clr) count <= '0;
        else if (inc)   count <= count + AW'(1);
    end
endmodule

// File: rtl/slc_cache.sv
module slc_cache #(
    parameter int N  = 234,
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] widx,
    input  logic          wbit,
    input  logic [AW-1:0] ridx,
    output logic          rbit
);
    localparam logic [AW-1:0] NLIM = AW'(N);

    logic [N-1:0] mem;

    always_ff @(posedge clk) begin
        if (rst)                    mem <= '0;
        else if (we && widx < NLIM) mem[widx] <= wbit;
    end

    assign rbit = (ridx < NLIM) ? mem[ridx] : 1'b0;
endmodule

// File: rtl/scan_cache_loader.sv
module scan_cache_loader
    import slc_pkg::*;
#(
    parameter  int CHAIN_KIND = 0,
    localparam int LEN        = chain_len(CHAIN_KIND),
    localparam int AW         = $clog2(LEN + 1)
) (
    input  logic          clk,
    input  logic          rst_in,
    input  logic          wr_rom,
    input  logic          rom_bit,
    input  logic          rst_addr,
    input  logic          reconfig,
    output logic [AW-1:0] rom_addr,
    output logic          rom_en,
    output logic          busy,
    output logic          scan_dout,
    output logic          scan_ce
);
    localparam logic [AW-1:0] LAST_IDX = AW'(LEN - 1);
    localparam logic [AW-1:0] END_IDX  = AW'(LEN);

    logic          rst_s;
    slc_state_e    state, nxt;
    logic [AW-1:0] sh_idx;
    logic [AW-1:0] cap_idx;
    logic          cap_vld;
    logic [AW-1:0] rd_idx;
    logic          rd_bit;
    logic          addr_clr;
    logic          addr_inc;

    slc_reset_sync #(.STAGES(2)) u_rst (
        .clk     (clk),
        .rst_in  (rst_in),
        .rst_out (rst_s)
    );

    // Next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (rst_addr)      nxt = ST_IDLE;
                else if (wr_rom)   nxt = ST_ARM;
                else if (reconfig) nxt = ST_SHIFT;
            end
            ST_ARM:   nxt = rst_addr ? ST_IDLE : ST_HOLD;
            ST_HOLD:  nxt = rst_addr ? ST_IDLE : ST_FETCH;
            ST_FETCH: begin
                if (rst_addr)                  nxt = ST_IDLE;
                else if (rom_addr == LAST_IDX) nxt = ST_DRAIN;
            end
            ST_DRAIN: nxt = ST_IDLE;
            ST_SHIFT: nxt = (sh_idx == END_IDX) ? ST_IDLE : ST_SHIFT;
            default:  nxt = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst_s) state <= ST_IDLE;
        else       state <= nxt;
    end

    assign addr_clr = rst_addr || (state == ST_HOLD && nxt == ST_FETCH);
    assign addr_inc = (state == ST_FETCH) && (nxt == ST_FETCH);
    assign rd_idx   = (state == ST_SHIFT) ? sh_idx : '0;

    slc_addr_ctr #(.AW(AW)) u_addr (
        .clk   (clk),
        .rst   (rst_s),
        .clr   (addr_clr),
        .inc   (addr_inc),
        .count (rom_addr)
    );

    slc_cache #(.N(LEN), .AW(AW)) u_cache (
        .clk  (clk),
        .rst  (rst_s),
        .we   (cap_vld),
        .widx (cap_idx),
        .wbit (rom_bit),
        .ridx (rd_idx),
        .rbit (rd_bit)
    );

    // Registered outputs and capture pipeline
    always_ff @(posedge clk) begin
        if (rst_s) begin
            busy      <= 1'b0;
            rom_en    <= 1'b0;
            scan_ce   <= 1'b0;
            scan_dout <= 1'b0;
            sh_idx    <= '0;
            cap_vld   <= 1'b0;
            cap_idx   <= '0;
        end else begin
            busy      <= (nxt != ST_IDLE);
            rom_en    <= (nxt == ST_FETCH);
            cap_vld   <= (state == ST_FETCH) && !rst_addr;
            cap_idx   <= rom_addr;
            scan_ce   <= (nxt == ST_SHIFT);
            scan_dout <= (nxt == ST_SHIFT) ? rd_bit : 1'b0;
            sh_idx    <= (state == ST_SHIFT) ? sh_idx + AW'(1) : AW'(1);
        end
    end
endmodule

// File: rtl/slc_checks.sv
module slc_checks #(
    parameter int LEN = 234,
    parameter int AW  = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          wr_rom,
    input logic          rst_addr,
    input logic [AW-1:0] rom_addr,
    input logic          rom_en,
    input logic          busy,
    input logic          scan_ce
);
    AST_BUSY_ON_REQ: assert property (@(posedge clk) disable iff (rst)
        (!busy && wr_rom && !rst_addr) |=> busy); // R2

    AST_EN_WITH_BUSY: assert property (@(posedge clk) disable iff (rst)
        rom_en |-> busy); // R3

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
        (rom_en && $past(rom_en)) |-> (rom_addr == AW'($past(rom_addr) + 1))); // R4

    AST_ADDR_BOUND: assert property (@(posedge clk) disable iff (rst)
        rom_en |-> (rom_addr < AW'(LEN))); // R5

    AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (rst)
        rst_addr |=> (!rom_en && rom_addr == '0)); // R6

    AST_SCAN_WITH_BUSY: assert property (@(posedge clk) disable iff (rst)
        scan_ce |-> (busy && !rom_en)); // R7

    AST_NO_READ_IN_SHIFT: assert property (@(posedge clk) disable iff (rst)
        scan_ce |=> !rom_en); // R8
endmodule

bind scan_cache_loader slc_checks #(.LEN(LEN), .AW(AW)) u_chk (
    .clk      (clk),
    .rst      (rst_s),
    .wr_rom   (wr_rom),
    .rst_addr (rst_addr),
    .rom_addr (rom_addr),
    .rom_en   (rom_en),
    .busy     (busy),
    .scan_ce  (scan_ce)
);

// File: tb/tb_scan_cache_loader.sv
module tb_scan_cache_loader;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_in = 1'b1, wr = 1'b0, rst_addr = 1'b0, reconfig = 1'b0;
    logic [7:0] addr_a, addr_b;
    logic [1:0] en_o, busy_o, sd_o, sce_o, rq;
    int seed = 0;
    int n_chk = 0, n_err = 0;
    bit done = 0;
    int lens[2] = '{234, 144};

    scan_cache_loader #(.CHAIN_KIND(0)) dut (
        .clk(clk), .rst_in(rst_in), .wr_rom(wr), .rom_bit(rq[0]),
        .rst_addr(rst_addr), .reconfig(reconfig), .rom_addr(addr_a),
        .rom_en(en_o[0]), .busy(busy_o[0]), .scan_dout(sd_o[0]), .scan_ce(sce_o[0]));

    scan_cache_loader #(.CHAIN_KIND(2)) dut_s (
        .clk(clk), .rst_in(rst_in), .wr_rom(wr), .rom_bit(rq[1]),
        .rst_addr(rst_addr), .reconfig(reconfig), .rom_addr(addr_b),
        .rom_en(en_o[1]), .busy(busy_o[1]), .scan_dout(sd_o[1]), .scan_ce(sce_o[1]));

    function automatic logic pat(input int s, input int a);
        if (s == 0) return 1'b1;
        if (s == 1) return (a % 2) == 1;
        return (((a * s) + (a >> 2)) ^ s) % 3 == 0;
    endfunction

    function automatic int addr_of(input int d);
        return (d == 0) ? int'(addr_a) : int'(addr_b);
    endfunction

    // ROM models: bit for the address seen at the previous edge
    always @(posedge clk) begin
        rq[0] <= en_o[0] ? pat(seed, int'(addr_a)) : 1'b0;
        rq[1] <= en_o[1] ? pat(seed, int'(addr_b)) : 1'b0;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
        end
    endtask

    task automatic idle_outputs(input string req);
        for (int d = 0; d < 2; d++) begin
            chk(busy_o[d] == 1'b0, req, busy_o[d], 0);
            chk(en_o[d] == 1'b0, req, en_o[d], 0);
            chk(sce_o[d] == 1'b0, req, sce_o[d], 0);
            chk(sd_o[d] == 1'b0, req, sd_o[d], 0);
        end
    endtask

    task automatic do_load(input int s, input bit inject);
        seed = s;
        @(negedge clk) wr = 1'b1;
        @(negedge clk) wr = 1'b0;
        for (int t = 0; t <= 242; t++) begin
            for (int d = 0; d < 2; d++) begin
                int L = lens[d];
                bit eb = (t <= L + 2);
                bit ee = (t >= 2 && t <= L + 1);
                int ea = (t <= L + 1) ? t - 2 : L - 1;
                chk(busy_o[d] == eb, (t == 0) ? "R2" : (inject ? "R8" : "R5"), busy_o[d], eb);
                chk(en_o[d] == ee, (t == 2) ? "R3" : "R5", en_o[d], ee);
                if (t >= 2)
                    chk(addr_of(d) == ea, (t == 2) ? "R3" : "R4", addr_of(d), ea);
            end
            if (inject) begin
                wr       = (t == 40);
                reconfig = (t == 40);
            end
            @(negedge clk);
        end
    endtask

    task automatic do_shift(input int s, input bit inject);
        @(negedge clk) reconfig = 1'b1;
        @(negedge clk) reconfig = 1'b0;
        for (int t = 0; t <= 236; t++) begin
            for (int d = 0; d < 2; d++) begin
                int L = lens[d];
                bit eb = (t < L);
                logic ed = (t < L) ? pat(s, t) : 1'b0;
                chk(busy_o[d] == eb, "R7", busy_o[d], eb);
                chk(sce_o[d] == eb, "R7", sce_o[d], eb);
                chk(sd_o[d] == ed, "R7", sd_o[d], ed);
                if (inject) begin
                    chk(en_o[d] == 1'b0, "R8", en_o[d], 0);
                    chk(addr_of(d) == L - 1, "R8", addr_of(d), L - 1);
                end
            end
            if (inject) wr = (t == 20);
            @(negedge clk);
        end
    endtask

    task automatic do_abort(input int s);
        seed = s;
        @(negedge clk) wr = 1'b1;
        @(negedge clk) wr = 1'b0;
        repeat (30) @(negedge clk);
        rst_addr = 1'b1;
        @(negedge clk) rst_addr = 1'b0;
        for (int d = 0; d < 2; d++) begin
            chk(busy_o[d] == 1'b0, "R6", busy_o[d], 0);
            chk(en_o[d] == 1'b0, "R6", en_o[d], 0);
            chk(addr_of(d) == 0, "R6", addr_of(d), 0);
        end
        repeat (3) @(negedge clk);
        idle_outputs("R6");
    endtask

    initial begin
        repeat (4) @(negedge clk);
        idle_outputs("R1");
        chk(addr_a == 0 && addr_b == 0, "R1", int'(addr_a), 0);
        rst_in = 1'b0;
        repeat (4) @(negedge clk);
        idle_outputs("R1");
        chk(addr_a == 0 && addr_b == 0, "R1", int'(addr_a), 0);

        do_load(0, 0);
        do_shift(0, 0);
        do_load(1, 1);
        do_shift(1, 1);
        do_abort(7);
        do_load(7, 0);
        do_shift(7, 0);

        // restart while idle: address held at L-1 must clear
        @(negedge clk) rst_addr = 1'b1;
        @(negedge clk) rst_addr = 1'b0;
        chk(addr_a == 0, "R6", int'(addr_a), 0);
        chk(addr_b == 0, "R6", int'(addr_b), 0);
        idle_outputs("R6");

        do_load(13, 0);
        do_shift(13, 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule